// File: doc/BRIEF.md
# Command-Addressed Configuration Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data). It oversamples both lines with a fast system clock and finds the bus conditions in that clock domain. After a START it checks the 7-bit device address and takes a one-byte command that selects a register. It then writes or reads that register one byte at a time. Three 10-bit tuning registers and two 5-bit registers can be written and read back. A 14-bit status value, supplied on an input port, can only be read.

Each register has its own byte layout. A 10-bit value goes out high part first, and its two low bits sit at the top of the second byte. The two 5-bit registers fill their unused upper bits differently on read: one returns ones and the other returns zeros. When a transfer that wrote a register ends at STOP, the block sends a one-cycle strobe with the command code to a commit controller. While that controller is busy, the block refuses every byte with a NACK.

Top module: `twi_cmd_regs`

## Requirements
- R1: A falling SDA while SCL is high (START) starts address reception, and a START in mid-transfer restarts it. A rising SDA while SCL is high (STOP) ends the transfer. Bytes clocked without a preceding START get no ACK.
- R2: The block only pulls SDA low and never drives it high. It changes its drive only while SCL is low. It ACKs by holding SDA low through the ninth clock. A write is address byte {7'h58, 0}, command, data. A read is {7'h58, 0}, command, repeated START, {7'h58, 1}.
- R3: An address byte whose upper seven bits differ from the device address gets a NACK. The block then ignores all traffic until the next START.
- R4: Commands 08h, 01h and 02h select 10-bit registers. Data byte 1 supplies bits [9:2], and bits [7:6] of data byte 2 supply bits [1:0]. The register changes only when byte 2 arrives. A read returns bits [9:2] first, then {bits[1:0], 6'b0}.
- R5: Command 0Eh stores bits [4:0] of its data byte. A read returns {3'b111, value}.
- R6: Command 0Dh stores bits [4:0] of its data byte. A read returns {3'b000, value}.
- R7: Command 37h reads the status input as status[13:6], then {status[5:1], 3'b000}. A data byte sent after 37h in a write gets a NACK and changes no register.
- R8: While busy_i is high, every byte gets a NACK, including the address. Normal ACKs resume once busy_i falls.
- R9: An unknown command byte gets a NACK. A data byte beyond the selected register's length (two bytes for 10-bit, one for 5-bit) gets a NACK and is not stored.
- R10: Read data goes out MSB first. A master ACK fetches the next byte. A master NACK makes the block release SDA until the next START or STOP.
- R11: A STOP that ends a transfer which completed at least one register write gives a one-cycle wr_done_o, with the command code on wr_cmd_o. Any other STOP gives no strobe.
- R12: After reset, all writable registers are zero, SDA is released and wr_done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| busy_i | input | 1 | Commit controller busy; forces NACK |
| status_i | input | 14 | Read-only status value (command 37h) |
| tune_o | output | 10 | Register for command 08h |
| presc_o | output | 10 | Register for command 01h |
| sel_o | output | 10 | Register for command 02h |
| trim_o | output | 5 | Register for command 0Eh |
| node_o | output | 5 | Register for command 0Dh |
| wr_done_o | output | 1 | One-cycle strobe at STOP after a register write |
| wr_cmd_o | output | 8 | Command code that goes with wr_done_o |

## Verification
The embedded assertions watch several rules on every cycle. SDA drive only starts while the synchronized SCL is low. An ACK never follows a decision made while busy_i was high. A 10-bit register changes only on the write of its second byte. The read-only command never reaches the write port, and the commit strobe is a single cycle. The bench scenarios are needed for the rest: the byte packing and fill values seen on the wire, address and command rejection, NACK of excess bytes, repeated START, master NACK on reads, and which STOP conditions produce a strobe.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 7;
    localparam int WIDE_W       = 10;
    localparam int NARROW_W     = 5;
    localparam int STAT_W       = 14;
    localparam int STAT_LO_W    = 5;
    localparam int IDX_W        = 2;
    localparam int WIDE_LO_W    = WIDE_W - BYTE_W;
    localparam int NARROW_PAD_W = BYTE_W - NARROW_W;
    localparam int STAT_LO_TOP  = STAT_W - BYTE_W - 1;
    localparam int CNT_W        = $clog2(BYTE_W + 1);

    typedef enum logic [BYTE_W-1:0] {
        CMD_TUNE  = 8'h08,
        CMD_PRESC = 8'h01,
        CMD_SEL   = 8'h02,
        CMD_TRIM  = 8'h0E,
        CMD_NODE  = 8'h0D,
        CMD_STAT  = 8'h37
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TXLD
    } bus_st_e;

    typedef struct packed {
        logic [WIDE_W-1:0]   tune;
        logic [WIDE_W-1:0]   presc;
        logic [WIDE_W-1:0]   sel;
        logic [NARROW_W-1:0] trim;
        logic [NARROW_W-1:0] node;
    } cfg_regs_t;

    function automatic logic cmd_is_wide(input logic [BYTE_W-1:0] c);
        return (c == CMD_TUNE) || (c == CMD_PRESC) || (c == CMD_SEL);
    endfunction

    function automatic logic cmd_writable(input logic [BYTE_W-1:0] c);
        return cmd_is_wide(c) || (c == CMD_TRIM) || (c == CMD_NODE);
    endfunction

    function automatic logic cmd_readable(input logic [BYTE_W-1:0] c);
        return cmd_writable(c) || (c == CMD_STAT);
    endfunction

    function automatic logic [IDX_W-1:0] cmd_len(input logic [BYTE_W-1:0] c);
        return (cmd_is_wide(c) || (c == CMD_STAT)) ? IDX_W'(2) : IDX_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_wide(input logic [WIDE_W-1:0] v,
                                                    input logic [IDX_W-1:0]  idx);
        case (idx)
            IDX_W'(0): return v[WIDE_W-1 -: BYTE_W];
            IDX_W'(1): return {v[WIDE_LO_W-1:0], {(BYTE_W-WIDE_LO_W){1'b0}}};
            default:   return '0;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_stat(input logic [STAT_W-1:0] s,
                                                    input logic [IDX_W-1:0]  idx);
        case (idx)
            IDX_W'(0): return s[STAT_W-1 -: BYTE_W];
            IDX_W'(1): return {s[STAT_LO_TOP -: STAT_LO_W], {(BYTE_W-STAT_LO_W){1'b0}}};
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi_o,
    output logic sda_bit_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic                   scl_d, sda_d;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_ff[TOP];
            sda_d <= sda_ff[TOP];
        end
    end

    assign scl_hi_o   = scl_ff[TOP];
    assign sda_bit_o  = sda_ff[TOP];
    assign scl_rise_o = scl_ff[TOP] & ~scl_d;
    assign scl_fall_o = ~scl_ff[TOP] & scl_d;
    assign start_o    = scl_ff[TOP] & scl_d & sda_d & ~sda_ff[TOP];
    assign stop_o     = scl_ff[TOP] & scl_d & ~sda_d & sda_ff[TOP];

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
    import twi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [BYTE_W-1:0]    cmd_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    input  logic [STAT_W-1:0]    status_i,
    output cfg_regs_t            regs_o,
    output logic [BYTE_W-1:0]    rdata_o,
    output logic                 wr_fin_o
);
    cfg_regs_t         regs_q;
    logic [BYTE_W-1:0] stage_q;
    logic [WIDE_W-1:0] wide_val;
    logic              stat_unused;

    assign stat_unused = status_i[0];
    assign wide_val    = {stage_q, wdata_i[BYTE_W-1 -: WIDE_LO_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q  <= '0;
            stage_q <= '0;
        end else if (wr_en_i) begin
            if (cmd_is_wide(cmd_i)) begin
                if (idx_i == IDX_W'(0)) begin
                    stage_q <= wdata_i;
                end else begin
                    case (cmd_i)
                        CMD_TUNE:  regs_q.tune  <= wide_val;
                        CMD_PRESC: regs_q.presc <= wide_val;
                        default:   regs_q.sel   <= wide_val;
                    endcase
                end
            end else if (cmd_i == CMD_TRIM) begin
                regs_q.trim <= wdata_i[NARROW_W-1:0];
            end else if (cmd_i == CMD_NODE) begin
                regs_q.node <= wdata_i[NARROW_W-1:0];
            end
        end
    end

    assign wr_fin_o = wr_en_i && (!cmd_is_wide(cmd_i) || (idx_i == IDX_W'(1)));
    assign regs_o   = regs_q;

    always_comb begin
        case (cmd_i)
            CMD_TUNE:  rdata_o = pack_wide(regs_q.tune, idx_i);
            CMD_PRESC: rdata_o = pack_wide(regs_q.presc, idx_i);
            CMD_SEL:   rdata_o = pack_wide(regs_q.sel, idx_i);
            CMD_TRIM:  rdata_o = (idx_i == IDX_W'(0)) ? {{NARROW_PAD_W{1'b1}}, regs_q.trim} : '0;
            CMD_NODE:  rdata_o = (idx_i == IDX_W'(0)) ? {{NARROW_PAD_W{1'b0}}, regs_q.node} : '0;
            CMD_STAT:  rdata_o = pack_stat(status_i, idx_i);
            default:   rdata_o = '0;
        endcase
    end

    // R7
    ro_stat_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> (cmd_i != CMD_STAT));

    // R4
    wide_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_q.tune) |-> $past(wr_en_i && (cmd_i == CMD_TUNE) && (idx_i == IDX_W'(1))));

    // R5
    trim_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_q.trim) |-> $past(wr_en_i && (cmd_i == CMD_TRIM)));

endmodule

// File: rtl/twi_cmd_regs.sv
module twi_cmd_regs
    import twi_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h58,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic                 busy_i,
    input  logic [STAT_W-1:0]    status_i,
    output logic [WIDE_W-1:0]    tune_o,
    output logic [WIDE_W-1:0]    presc_o,
    output logic [WIDE_W-1:0]    sel_o,
    output logic [NARROW_W-1:0]  trim_o,
    output logic [NARROW_W-1:0]  node_o,
    output logic                 wr_done_o,
    output logic [BYTE_W-1:0]    wr_cmd_o
);
    logic scl_hi, sda_bit, scl_rise, scl_fall, start_ev, stop_ev;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_hi_o   (scl_hi),
        .sda_bit_o  (sda_bit),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    bus_st_e           st_q, ack_to_q, ack_to;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q, cmd_q, rdata;
    logic [IDX_W-1:0]  idx_q;
    logic              cmd_ok_q, wr_seen_q, oe_q, done_q;
    logic              accept, byte_end, wr_en, wr_fin;
    cfg_regs_t         regs;

    twi_reg_bank i_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .cmd_i    (cmd_q),
        .idx_i    (idx_q),
        .wdata_i  (shreg_q),
        .status_i (status_i),
        .regs_o   (regs),
        .rdata_o  (rdata),
        .wr_fin_o (wr_fin)
    );

    always_comb begin
        accept = 1'b0;
        ack_to = ST_IDLE;
        case (st_q)
            ST_ADDR: begin
                if ((shreg_q[BYTE_W-1:1] == DEV_ADDR) && !busy_i) begin
                    if (shreg_q[0]) begin
                        accept = cmd_ok_q;
                        ack_to = ST_TX;
                    end else begin
                        accept = 1'b1;
                        ack_to = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                accept = !busy_i && cmd_readable(shreg_q);
                ack_to = ST_WDATA;
            end
            ST_WDATA: begin
                accept = !busy_i && cmd_writable(cmd_q) && (idx_q < cmd_len(cmd_q));
                ack_to = ST_WDATA;
            end
            default: ;
        endcase
    end

    assign byte_end = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));
    assign wr_en    = (st_q == ST_WDATA) && byte_end && accept && !start_ev && !stop_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ack_to_q  <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            cmd_q     <= '0;
            idx_q     <= '0;
            cmd_ok_q  <= 1'b0;
            wr_seen_q <= 1'b0;
            oe_q      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_ev) begin
                st_q      <= ST_ADDR;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
            end else if (stop_ev) begin
                st_q      <= ST_IDLE;
                oe_q      <= 1'b0;
                cmd_ok_q  <= 1'b0;
                done_q    <= wr_seen_q;
                wr_seen_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && (bit_cnt_q != CNT_W'(BYTE_W))) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_bit};
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end else if (byte_end) begin
                            bit_cnt_q <= '0;
                            if (accept) begin
                                oe_q     <= 1'b1;
                                st_q     <= ST_ACK;
                                ack_to_q <= ack_to;
                                if (st_q == ST_ADDR) begin
                                    idx_q <= '0;
                                end else if (st_q == ST_CMD) begin
                                    cmd_q    <= shreg_q;
                                    cmd_ok_q <= 1'b1;
                                    idx_q    <= '0;
                                end else begin
                                    idx_q <= idx_q + IDX_W'(1);
                                    if (wr_fin) wr_seen_q <= 1'b1;
                                end
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (ack_to_q == ST_TX) begin
                                shreg_q <= rdata;
                                oe_q    <= ~rdata[BYTE_W-1];
                                st_q    <= ST_TX;
                            end else begin
                                oe_q <= 1'b0;
                                st_q <= ack_to_q;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
                                oe_q      <= 1'b0;
                                st_q      <= ST_MACK;
                                bit_cnt_q <= '0;
                            end else begin
                                shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
                                oe_q      <= ~shreg_q[BYTE_W-2];
                                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_bit) begin
                                st_q <= ST_IDLE;
                            end else begin
                                if (idx_q != '1) idx_q <= idx_q + IDX_W'(1);
                                st_q <= ST_TXLD;
                            end
                        end
                    end
                    ST_TXLD: begin
                        if (scl_fall) begin
                            shreg_q   <= rdata;
                            oe_q      <= ~rdata[BYTE_W-1];
                            bit_cnt_q <= '0;
                            st_q      <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o  = oe_q;
    assign wr_done_o = done_q;
    assign wr_cmd_o  = cmd_q;
    assign tune_o    = regs.tune;
    assign presc_o   = regs.presc;
    assign sel_o     = regs.sel;
    assign trim_o    = regs.trim;
    assign node_o    = regs.node;

    // R2
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_hi);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe_o) && (st_q == ST_ACK)) |-> !$past(busy_i));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done_o |=> !wr_done_o);

endmodule

// File: tb/test_twi_cmd_regs.sv
module test_twi_cmd_regs;
    import twi_cmd_pkg::*;

    localparam int          Q    = 8;
    localparam logic [6:0]  DEV  = 7'h58;
    localparam logic [13:0] STAT = 14'h2D5B;

    logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic        sda_oe, wr_done;
    logic [7:0]  wr_cmd;
    logic [9:0]  tune, presc, sel;
    logic [4:0]  trim, node;
    wire         sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twi_cmd_regs i_twi_cmd_regs (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .busy_i(busy), .status_i(STAT), .tune_o(tune), .presc_o(presc), .sel_o(sel),
        .trim_o(trim), .node_o(node), .wr_done_o(wr_done), .wr_cmd_o(wr_cmd)
    );

    int n_chk = 0, n_err = 0, strobes = 0;
    logic [7:0] last_cmd = 8'h00;
    logic done = 1'b0;

    always @(posedge clk) if (!rst && wr_done) begin
        strobes  <= strobes + 1;
        last_cmd <= wr_cmd;
    end

    typedef struct packed {
        logic [7:0] cmd; logic [7:0] d0; logic [7:0] d1; logic [1:0] n;
        logic [9:0] val; logic [7:0] r0; logic [7:0] r1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h08, 8'hA5, 8'hC0, 2'd2, 10'h297, 8'hA5, 8'hC0},  // R4
        '{8'h01, 8'h3C, 8'h7F, 2'd2, 10'h0F1, 8'h3C, 8'h40},  // R4
        '{8'h02, 8'hFF, 8'h3F, 2'd2, 10'h3FC, 8'hFF, 8'h00},  // R4
        '{8'h0E, 8'hA7, 8'h00, 2'd1, 10'h007, 8'hE7, 8'h00},  // R5
        '{8'h0D, 8'hFA, 8'h00, 2'd1, 10'h01A, 8'h1A, 8'h00},  // R6
        '{8'h0E, 8'h00, 8'h00, 2'd1, 10'h000, 8'hE0, 8'h00}   // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] reg_of(input logic [7:0] c);
        case (c)
            8'h08:   return tune;
            8'h01:   return presc;
            8'h02:   return sel;
            8'h0E:   return {5'd0, trim};
            8'h0D:   return {5'd0, node};
            default: return 10'h3FF;
        endcase
    endfunction

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); s = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); b[i] = s; end
        bus_bit(~mack, s);
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] cmd, input logic [7:0] d0,
                            input logic [7:0] d1, input int n, output logic [3:0] acks);
        acks = 4'b0000;
        bus_start;
        send_byte({dev, 1'b0}, acks[0]);
        send_byte(cmd, acks[1]);
        if (n > 0) send_byte(d0, acks[2]);
        if (n > 1) send_byte(d1, acks[3]);
        bus_stop;
        wq(4);
    endtask

    task automatic do_read(input logic [7:0] cmd, input int n, output logic [7:0] b0,
                           output logic [7:0] b1, output logic [2:0] acks);
        b1 = 8'h00;
        bus_start;
        send_byte({DEV, 1'b0}, acks[0]);
        send_byte(cmd, acks[1]);
        bus_start;
        send_byte({DEV, 1'b1}, acks[2]);
        recv_byte(n > 1, b0);
        if (n > 1) recv_byte(1'b0, b1);
        bus_stop;
        wq(4);
    endtask

    initial begin
        logic [3:0] wa;
        logic [2:0] ra;
        logic [7:0] b0, b1;
        logic       a;
        int         s0;
        logic [9:0] keep;

        wq(5); rst = 1'b0; wq(3);
        // R12 reset state
        chk("R12 tune", tune, 0);  chk("R12 presc", presc, 0); chk("R12 sel", sel, 0);
        chk("R12 trim", trim, 0);  chk("R12 node", node, 0);
        chk("R12 sda_oe", sda_oe, 0); chk("R12 wr_done", wr_done, 0);

        for (int v = 0; v < 6; v++) begin
            s0 = strobes;
            do_write(DEV, VECS[v].cmd, VECS[v].d0, VECS[v].d1, int'(VECS[v].n), wa);
            chk($sformatf("R2 write acks vec%0d", v), wa, (VECS[v].n == 2) ? 4'b1111 : 4'b0111);
            chk($sformatf("R%0d reg value vec%0d", (VECS[v].cmd == 8'h0D) ? 6 : (VECS[v].n == 2 ? 4 : 5), v),
                reg_of(VECS[v].cmd), VECS[v].val);
            chk("R11 strobe count", strobes, s0 + 1);
            chk("R11 strobe cmd", last_cmd, VECS[v].cmd);
            do_read(VECS[v].cmd, int'(VECS[v].n), b0, b1, ra);
            chk("R2 read acks", ra, 3'b111);
            chk($sformatf("R10 read byte0 vec%0d", v), b0, VECS[v].r0);
            if (VECS[v].n == 2) chk($sformatf("R10 read byte1 vec%0d", v), b1, VECS[v].r1);
        end

        // R7 status read packing
        do_read(8'h37, 2, b0, b1, ra);
        chk("R7 status acks", ra, 3'b111);
        chk("R7 status byte0", b0, STAT[13:6]);
        chk("R7 status byte1", b1, {STAT[5:1], 3'b000});

        // R7 write to read-only register: data NACK, no strobe
        s0 = strobes;
        do_write(DEV, 8'h37, 8'h55, 8'h00, 1, wa);
        chk("R7 ro write acks", wa, 4'b0011);
        chk("R11 no strobe after rejected write", strobes, s0);

        // R3 wrong address
        keep = tune;
        do_write(7'h21, 8'h08, 8'h12, 8'h40, 2, wa);
        chk("R3 bad address acks", wa, 4'b0000);
        chk("R3 tune untouched", tune, keep);

        // R9 unknown command
        do_write(DEV, 8'h55, 8'h01, 8'h00, 1, wa);
        chk("R9 unknown cmd acks", wa, 4'b0001);

        // R9 extra byte on a narrow register
        s0 = strobes;
        do_write(DEV, 8'h0D, 8'h03, 8'h04, 2, wa);
        chk("R9 narrow extra byte acks", wa, 4'b0111);
        chk("R9 node keeps first byte", node, 5'h03);
        chk("R11 one strobe", strobes, s0 + 1);

        // R4 only first byte of a wide register
        s0 = strobes;
        keep = tune;
        do_write(DEV, 8'h08, 8'h11, 8'h00, 1, wa);
        chk("R4 half write acks", wa, 4'b0111);
        chk("R4 tune unchanged by half write", tune, keep);
        chk("R11 no strobe for half write", strobes, s0);

        // R8 busy
        busy = 1'b1;
        keep = presc;
        do_write(DEV, 8'h01, 8'h33, 8'h80, 2, wa);
        chk("R8 busy acks", wa, 4'b0000);
        chk("R8 presc unchanged", presc, keep);
        busy = 1'b0;
        do_write(DEV, 8'h01, 8'h33, 8'h80, 2, wa);
        chk("R8 after busy acks", wa, 4'b1111);
        chk("R8 presc written", presc, 10'h0CE);

        // R10 master NACK releases SDA
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h08, a);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        chk("R10 read address ack", a, 1'b1);
        recv_byte(1'b0, b0);
        chk("R10 first byte", b0, tune[9:2]);
        recv_byte(1'b0, b1);
        chk("R10 released after master NACK", b1, 8'hFF);
        bus_stop; wq(4);

        // R1 repeated START restarts address phase
        bus_start;
        send_byte({DEV, 1'b0}, a);
        bus_start;
        send_byte({DEV, 1'b0}, wa[0]);
        send_byte(8'h0E, wa[1]);
        send_byte(8'h15, wa[2]);
        bus_stop; wq(4);
        chk("R1 restart acks", wa[2:0], 3'b111);
        chk("R1 trim after restart", trim, 5'h15);

        // R1 bytes without START are ignored
        scl_m = 1'b0; wq(Q);
        send_byte({DEV, 1'b0}, a);
        chk("R1 no ack without START", a, 1'b0);
        bus_stop; wq(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule